// File: doc/BRIEF.md
# Serial Character Receiver

This block turns a serial line into parallel characters. It runs on the system clock and advances only on cycles where the receive-clock enable is high, so one enable pulse stands for one period of the external receive clock. Each finished character goes into a one-character holding register, and `rx_rdy` stays high until the host pulses `data_rd`. While `rx_enable` is low the receiver stays idle and takes in nothing.

In asynchronous mode the receive clock runs at 1, 16 or 64 times the bit rate. The receiver confirms a start bit at its midpoint, then samples every later bit at its centre, least significant data bit first. An optional parity bit follows the data, then one stop bit. It reports parity errors, framing errors, overrun and a break condition. In synchronous mode there is one bit per receive-clock pulse and no start or stop bits. In internal-sync mode the receiver shifts the line through a window until the window equals the programmed sync character. It then raises `sync_det` and assembles characters back to back. In external-sync mode a high level on `sync_in` starts assembly at the next bit.

Top module: `serial_rx_core`

## Requirements
- R1: While `rx_enable` is low, no character is accepted and `rx_rdy` does not rise.
- R2: In asynchronous mode, with `baud_sel` 00 = x1, 01 = x16 and 1x = x64, a frame is read as start bit (low), data bits LSB first, optional parity bit, and one stop bit. Each bit is sampled at its centre. The byte appears on `rx_data` with `rx_rdy` high, and a `data_rd` pulse clears `rx_rdy`.
- R3: A low level on the idle line that is gone before the start-bit midpoint is rejected and produces no character.
- R4: When `par_en` is 1, `err_parity` is set if the received data and parity bit together hold an odd count of ones while `par_odd` = 0, or an even count while `par_odd` = 1.
- R5: `err_frame` is set when the stop bit is sampled low.
- R6: If a character completes while `rx_rdy` is still high and no read happens in that cycle, `err_overrun` is set and `rx_data` holds the newer character.
- R7: The three error flags stay set, even through later error-free characters, until `err_clear` is pulsed.
- R8: In asynchronous mode, `brk_det` rises when the stop-bit samples of two consecutive characters are both low. It falls on the first receive-clock pulse that sees the line high.
- R9: In internal-sync mode (`sync_mode` = 1, `ext_sync` = 0), `sync_det` rises once the last 8 received bits equal `sync_char`, first-received bit in bit 0. Characters are then assembled back to back, and a `stat_rd` pulse clears `sync_det`.
- R10: In external-sync mode (`ext_sync` = 1), the receive-clock pulse on which `sync_in` is high starts assembly, the next bit is data bit 0, and `sync_det` stays low.
- R11: After reset, `rx_rdy`, all error flags, `brk_det` and `sync_det` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxc_en | input | 1 | One pulse per receive-clock period |
| rx_line | input | 1 | Serial data line |
| rx_enable | input | 1 | Receiver enable command bit |
| err_clear | input | 1 | Pulse: clear error flags |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| ext_sync | input | 1 | In synchronous mode, 1 selects the external sync start |
| baud_sel | input | 2 | Asynchronous clock factor: 00 x1, 01 x16, 1x x64 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| sync_char | input | DATA_W | Character hunted for in internal-sync mode |
| sync_in | input | 1 | External sync start level |
| data_rd | input | 1 | Pulse: host read of the holding register |
| stat_rd | input | 1 | Pulse: host read of status |
| rx_data | output | DATA_W | Holding register |
| rx_rdy | output | 1 | Character waiting |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Break detected |
| sync_det | output | 1 | Internal sync found |

## Verification
The assertions assume that `data_rd`, `stat_rd` and `err_clear` are single-cycle pulses. They also assume the mode, factor, parity and sync-character inputs change only while the receiver is disabled or idle between frames, since a mid-frame change would redefine the bit positions under way. The stimulus follows these rules. Each pulse is driven for exactly one clock at the falling edge. Formats change only after the previous frame's trailing idle time, and every switch between the asynchronous, internal-sync and external-sync modes is done with `rx_enable` low.

// File: rtl/rx_pkg.sv
`timescale 1ns/1ps
package rx_pkg;
  localparam int MAX_DIV = 64;

  typedef enum logic [1:0] {TM_IDLE, TM_START, TM_RUN} tm_state_e;

  // receive-clock pulses per bit in asynchronous mode
  function automatic int div_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 16;
      default: return MAX_DIV;
    endcase
  endfunction

  // mismatch between the ones-count of data plus parity bit and the wanted sense
  function automatic logic parity_wrong(input logic data_xor, input logic pbit,
                                        input logic odd_sel);
    return (data_xor ^ pbit) != odd_sel;
  endfunction
endpackage

// File: rtl/rx_bit_timer.sv
`timescale 1ns/1ps
module rx_bit_timer import rx_pkg::*; #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             line,
  input  logic [CNT_W-1:0] last_cnt,
  input  logic [CNT_W-1:0] half,
  input  logic             frame_end,
  output logic             start_ok,
  output logic             samp_stb
);
  tm_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    start_ok = 1'b0;
    samp_stb = active && tick && (st == TM_RUN) && (cnt == last_cnt);
    if (active && tick) begin
      if (st == TM_IDLE && !line && half == '0) start_ok = 1'b1;
      if (st == TM_START && cnt == half && !line) start_ok = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= TM_IDLE;
      cnt <= '0;
    end else if (!active) begin
      st  <= TM_IDLE;
      cnt <= '0;
    end else if (tick) begin
      unique case (st)
        TM_IDLE: if (!line) begin
          if (half == '0) begin
            st  <= TM_RUN;
            cnt <= '0;
          end else begin
            st  <= TM_START;
            cnt <= CNT_W'(1);
          end
        end
        TM_START: if (cnt == half) begin
          st  <= line ? TM_IDLE : TM_RUN;
          cnt <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        TM_RUN: if (cnt == last_cnt) begin
          cnt <= '0;
          if (frame_end) st <= TM_IDLE;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: st <= TM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_framer.sv
`timescale 1ns/1ps
module rx_framer #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_mode,
  input  logic              ext_sync,
  input  logic              tick,
  input  logic              line,
  input  logic              sync_in,
  input  logic              start_ok,
  input  logic              samp_stb,
  input  logic              par_en,
  input  logic [DATA_W-1:0] sync_char,
  output logic              char_done,
  output logic              sync_hit,
  output logic [DATA_W-1:0] char_data,
  output logic              par_bit,
  output logic              stop_bad
);
  localparam logic [IDX_W-1:0] IDX_DW = IDX_W'(DATA_W);

  logic              active;
  logic [IDX_W-1:0]  idx, fill, last_idx;
  logic [DATA_W-1:0] shreg, hunt, hunt_nx;
  logic              par_q, bit_stb, hunt_tick;

  always_comb begin
    bit_stb   = active && (sync_mode ? tick : samp_stb);
    // async frame: data + parity + stop; sync frame: data + parity
    last_idx  = IDX_DW + IDX_W'(par_en) - IDX_W'(sync_mode);
    char_done = enable && bit_stb && (idx == last_idx);
    char_data = (idx < IDX_DW) ? {line, shreg[DATA_W-1:1]} : shreg;
    par_bit   = (idx == IDX_DW) ? line : par_q;
    stop_bad  = !sync_mode && !line;
    hunt_tick = enable && sync_mode && !active && tick;
    hunt_nx   = {line, hunt[DATA_W-1:1]};
    sync_hit  = hunt_tick && !ext_sync && (fill >= IDX_DW - IDX_W'(1)) &&
                (hunt_nx == sync_char);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      fill   <= '0;
      shreg  <= '0;
      hunt   <= '0;
      par_q  <= 1'b0;
    end else if (!enable) begin
      active <= 1'b0;
      idx    <= '0;
      fill   <= '0;
    end else begin
      if (!sync_mode && start_ok) begin
        active <= 1'b1;
        idx    <= '0;
      end
      if (hunt_tick) begin
        if (ext_sync) begin
          if (sync_in) begin
            active <= 1'b1;
            idx    <= '0;
          end
        end else begin
          hunt <= hunt_nx;
          if (fill != IDX_DW) fill <= fill + IDX_W'(1);
          if (sync_hit) begin
            active <= 1'b1;
            idx    <= '0;
          end
        end
      end
      if (bit_stb) begin
        if (idx < IDX_DW) shreg <= {line, shreg[DATA_W-1:1]};
        if (idx == IDX_DW) par_q <= line;
        if (idx == last_idx) begin
          idx <= '0;
          if (!sync_mode) active <= 1'b0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rx_status.sv
`timescale 1ns/1ps
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_on,
  input  logic              tick,
  input  logic              line,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              par_bad,
  input  logic              stop_bad,
  input  logic              sync_hit,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              err_clear,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det,
  output logic              sync_det
);
  logic prev_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_rdy      <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      brk_det     <= 1'b0;
      prev_low    <= 1'b0;
      sync_det    <= 1'b0;
    end else begin
      if (char_done) begin
        rx_data <= char_data;
        rx_rdy  <= 1'b1;
      end else if (data_rd) begin
        rx_rdy  <= 1'b0;
      end
      err_parity  <= (err_parity && !err_clear) || (char_done && par_bad);
      err_frame   <= (err_frame && !err_clear) || (char_done && stop_bad);
      err_overrun <= (err_overrun && !err_clear) || (char_done && rx_rdy && !data_rd);
      if (!async_on || (tick && line)) begin
        brk_det  <= 1'b0;
        prev_low <= 1'b0;
      end else if (char_done) begin
        prev_low <= stop_bad;
        if (stop_bad && prev_low) brk_det <= 1'b1;
      end
      if (sync_hit)     sync_det <= 1'b1;
      else if (stat_rd) sync_det <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
`timescale 1ns/1ps
module serial_rx_core import rx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc_en,
  input  logic              rx_line,
  input  logic              rx_enable,
  input  logic              err_clear,
  input  logic              sync_mode,
  input  logic              ext_sync,
  input  logic [1:0]        baud_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              sync_in,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det,
  output logic              sync_det
);
  localparam int CNT_W = $clog2(MAX_DIV + 1);
  localparam int IDX_W = $clog2(DATA_W + 2);

  logic [CNT_W-1:0]  last_cnt, half;
  logic              async_on, start_ok, samp_stb;
  logic              char_done, sync_hit, par_bit, stop_bad, par_bad;
  logic [DATA_W-1:0] char_data;

  assign last_cnt = CNT_W'(div_of(baud_sel) - 1);
  assign half     = CNT_W'(div_of(baud_sel) / 2);
  assign async_on = rx_enable && !sync_mode;
  assign par_bad  = par_en && parity_wrong(^char_data, par_bit, par_odd);

  rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(async_on), .tick(rxc_en), .line(rx_line),
    .last_cnt(last_cnt), .half(half), .frame_end(char_done),
    .start_ok(start_ok), .samp_stb(samp_stb)
  );

  rx_framer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable), .sync_mode(sync_mode),
    .ext_sync(ext_sync), .tick(rxc_en), .line(rx_line), .sync_in(sync_in),
    .start_ok(start_ok), .samp_stb(samp_stb), .par_en(par_en),
    .sync_char(sync_char), .char_done(char_done), .sync_hit(sync_hit),
    .char_data(char_data), .par_bit(par_bit), .stop_bad(stop_bad)
  );

  rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .async_on(async_on), .tick(rxc_en), .line(rx_line),
    .char_done(char_done), .char_data(char_data), .par_bad(par_bad),
    .stop_bad(stop_bad), .sync_hit(sync_hit), .data_rd(data_rd),
    .stat_rd(stat_rd), .err_clear(err_clear), .rx_data(rx_data),
    .rx_rdy(rx_rdy), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .brk_det(brk_det), .sync_det(sync_det)
  );
endmodule

// File: rtl/serial_rx_chk.sv
`timescale 1ns/1ps
module serial_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_enable,
  input logic ext_sync,
  input logic data_rd,
  input logic stat_rd,
  input logic err_clear,
  input logic char_done,
  input logic stop_bad,
  input logic sync_hit,
  input logic rx_rdy,
  input logic err_parity,
  input logic err_frame,
  input logic err_overrun,
  input logic brk_det,
  input logic sync_det
);
  p_off_no_char_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !rx_rdy) |=> !rx_rdy);

  p_rdy_after_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_rdy);

  p_rdy_drop_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_rdy) |-> $past(data_rd));

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_rdy && !data_rd) |=> err_overrun);

  p_parity_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !err_clear) |=> err_parity);

  p_frame_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !err_clear) |=> err_frame);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !err_clear) |=> err_overrun);

  p_break_from_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> $past(char_done && stop_bad));

  p_sync_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sync_hit) |=> !sync_det);

  p_ext_no_syndet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sync && !sync_det) |=> !sync_det);
endmodule

bind serial_rx_core serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ext_sync(ext_sync),
  .data_rd(data_rd), .stat_rd(stat_rd), .err_clear(err_clear),
  .char_done(char_done), .stop_bad(stop_bad), .sync_hit(sync_hit),
  .rx_rdy(rx_rdy), .err_parity(err_parity), .err_frame(err_frame),
  .err_overrun(err_overrun), .brk_det(brk_det), .sync_det(sync_det)
);

// File: tb/tb_serial_rx_core.sv
`timescale 1ns/1ps
module tb_serial_rx_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rxc_en = 1'b1, rx_line = 1'b1, rx_enable = 1'b0, err_clear = 1'b0;
  logic sync_mode = 1'b0, ext_sync = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] baud_sel = 2'b01;
  logic [7:0] sync_char = 8'h16;
  logic sync_in = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_rdy, err_parity, err_frame, err_overrun, brk_det, sync_det;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_rx_core dut (
    .clk(clk), .rst_n(rst_n), .rxc_en(rxc_en), .rx_line(rx_line),
    .rx_enable(rx_enable), .err_clear(err_clear), .sync_mode(sync_mode),
    .ext_sync(ext_sync), .baud_sel(baud_sel), .par_en(par_en), .par_odd(par_odd),
    .sync_char(sync_char), .sync_in(sync_in), .data_rd(data_rd), .stat_rd(stat_rd),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det),
    .sync_det(sync_det)
  );

  // {ferr, perr, stop_low, flip_par, odd, par_en, baud_sel[1:0], data[7:0]}
  localparam logic [15:0] VEC [8] = '{
    16'h01A5, 16'h043C, 16'h0E81, 16'h557E,
    16'h5D00, 16'hA1C3, 16'h0CFF, 16'hF65A
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    cyc(n);
  endtask

  task automatic pulse_rd();
    data_rd = 1'b1; cyc(1); data_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clear = 1'b1; cyc(1); err_clear = 1'b0;
  endtask

  function automatic int ticks_per_bit(input logic [1:0] s);
    if (s[1]) return 64;
    return s[0] ? 16 : 1;
  endfunction

  task automatic send_async(input logic [7:0] d, input int f, input logic pe,
                            input logic po, input logic flip, input logic stop_v);
    logic pb;
    pb = (^d) ^ po ^ flip;
    hold(1'b0, f);
    for (int i = 0; i < 8; i++) hold(d[i], f);
    if (pe) hold(pb, f);
    hold(stop_v, f);
    hold(1'b1, 4);
  endtask

  task automatic send_sync(input logic [7:0] d);
    for (int i = 0; i < 8; i++) hold(d[i], 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R11 reset state
    chk("R11 rdy", rx_rdy, 0);
    chk("R11 perr", err_parity, 0);
    chk("R11 ferr", err_frame, 0);
    chk("R11 ovr", err_overrun, 0);
    chk("R11 brk", brk_det, 0);
    chk("R11 syndet", sync_det, 0);

    rx_enable = 1'b1;
    cyc(2);
    // R2 R4 R5: async vector table
    for (int v = 0; v < 8; v++) begin
      pulse_clr();
      baud_sel = VEC[v][9:8];
      par_en   = VEC[v][10];
      par_odd  = VEC[v][11];
      cyc(2);
      send_async(VEC[v][7:0], ticks_per_bit(VEC[v][9:8]), VEC[v][10], VEC[v][11],
                 VEC[v][12], !VEC[v][13]);
      chk("R2 vec rdy", rx_rdy, 1);
      chk("R2 vec data", rx_data, VEC[v][7:0]);
      chk("R4 vec perr", err_parity, VEC[v][14]);
      chk("R5 vec ferr", err_frame, VEC[v][15]);
      chk("R6 vec ovr", err_overrun, 0);
      pulse_rd();
      chk("R2 rdy cleared", rx_rdy, 0);
      cyc(80);
    end

    // R3 start glitch
    baud_sel = 2'b01; par_en = 1'b0; pulse_clr();
    hold(1'b0, 5);
    hold(1'b1, 40);
    chk("R3 glitch no char", rx_rdy, 0);
    send_async(8'h42, 16, 0, 0, 0, 1);
    chk("R3 after glitch data", rx_data, 8'h42);
    pulse_rd();

    // R6 overrun, R7 sticky flags
    pulse_clr();
    send_async(8'h11, 16, 0, 0, 0, 1);
    send_async(8'h22, 16, 0, 0, 0, 1);
    chk("R6 overrun", err_overrun, 1);
    chk("R6 newest data", rx_data, 8'h22);
    par_en = 1'b1; par_odd = 1'b0; cyc(2);
    send_async(8'h33, 16, 1, 0, 1, 1);
    chk("R4 parity bad", err_parity, 1);
    chk("R7 overrun held", err_overrun, 1);
    pulse_rd();
    send_async(8'h44, 16, 1, 0, 0, 1);
    chk("R7 parity held", err_parity, 1);
    chk("R7 good data", rx_data, 8'h44);
    pulse_clr();
    cyc(1);
    chk("R7 clear perr", err_parity, 0);
    chk("R7 clear ovr", err_overrun, 0);
    pulse_rd();

    // R8 break
    par_en = 1'b0; cyc(2); pulse_clr();
    hold(1'b0, 330);
    chk("R8 break set", brk_det, 1);
    chk("R5 break frame", err_frame, 1);
    hold(1'b1, 2);
    chk("R8 break cleared", brk_det, 0);
    cyc(250);
    pulse_rd(); pulse_clr();
    cyc(2);

    // R1 disabled
    rx_enable = 1'b0; cyc(2);
    send_async(8'h99, 16, 0, 0, 0, 1);
    chk("R1 no char", rx_rdy, 0);

    // R9 internal sync
    sync_mode = 1'b1; ext_sync = 1'b0; sync_char = 8'h16;
    cyc(2);
    rx_enable = 1'b1;
    hold(1'b1, 3);
    send_sync(8'h16);
    chk("R9 syndet set", sync_det, 1);
    chk("R9 no char yet", rx_rdy, 0);
    send_sync(8'hC5);
    chk("R9 first rdy", rx_rdy, 1);
    chk("R9 first data", rx_data, 8'hC5);
    send_sync(8'h3A);
    chk("R9 second data", rx_data, 8'h3A);
    chk("R9 syndet kept", sync_det, 1);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    chk("R9 syndet cleared", sync_det, 0);

    // R10 external sync
    rx_enable = 1'b0; ext_sync = 1'b1; cyc(2);
    pulse_rd(); pulse_clr();
    rx_enable = 1'b1;
    hold(1'b0, 3);
    hold(1'b1, 3);
    chk("R10 no start without sync_in", rx_rdy, 0);
    sync_in = 1'b1; hold(1'b1, 1); sync_in = 1'b0;
    send_sync(8'h6B);
    chk("R10 rdy", rx_rdy, 1);
    chk("R10 data", rx_data, 8'h6B);
    chk("R10 syndet low", sync_det, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule